// File: doc/BRIEF.md
# Inter-processor interrupt command issuer

This unit turns a 64-bit interrupt command word into one outbound interrupt message. Software writes the command in two 32-bit halves. A write to the upper half only records the 8-bit target ID. A write to the lower half latches the vector, delivery kind, destination mode, trigger mode and shorthand, and it starts a send.

After one cycle of checking, a legal command proceeds in one of three ways. It can be delivered locally through a one-cycle self-delivery strobe. It can be offered on a valid/ready message port. A command can also do both, in which case the local strobe always comes first. When a shorthand is used, the stored target ID is replaced by an all-ones broadcast address in physical mode.

An illegal combination produces neither a message nor a strobe. Instead it sets a sticky error flag. A busy output covers the whole time a command is in flight. Writes that arrive while busy are discarded and recorded in a second sticky flag.

Top module: `ipi_issuer`

## Requirements
- R1: After reset, busy, msg_valid, self_strobe, err_illegal and err_overrun are all 0.
- R2: A write with wr_hi=1 while idle stores wr_data[31:24] as the target ID (command bits 63:56). It starts nothing: busy stays 0 and no message or strobe appears.
- R3: A write with wr_hi=0 while idle starts a send. The fields are: vector in bits 7:0, delivery kind in bits 10:8, destination mode in bit 11, trigger in bit 15 (1 = level) and shorthand in bits 19:18. With shorthand 00 and edge trigger, every delivery kind is legal. The result is one message carrying the vector, the delivery kind, bit 11, and the stored target ID.
- R4: Any command with bit 15 = 1 is illegal, whatever the shorthand. It causes no message and no strobe, sets err_illegal, and busy falls two cycles after the write.
- R5: Shorthand 01 (self) is legal only with delivery kind 000 (fixed). A legal self command gives exactly one self_strobe with self_vector equal to the vector, and no message. Any other kind is illegal.
- R6: Shorthand 10 (everyone, issuer included) is legal only with delivery kind 000. A legal command first pulses self_strobe and then sends a message with msg_dest = 8'hFF, msg_dmode = 0 and msg_excl_self = 0.
- R7: Shorthand 11 (everyone except issuer) is legal with every delivery kind. It sends a message with msg_dest = 8'hFF, msg_dmode = 0 and msg_excl_self = 1, and the stored target ID has no effect.
- R8: With shorthand 11 and delivery kind 001 (lowest priority), a self_strobe comes before the message when parameter SELF_ON_LOWPRI = 1. When SELF_ON_LOWPRI = 0 there is no self_strobe.
- R9: While msg_valid=1 and msg_ready=0, the message and its fields hold unchanged. busy is 1 from the cycle after the starting write until the handshake completes, or until the strobe of a self-only command.
- R10: Any write while busy=1 is ignored, including writes to the upper half, and sets err_overrun.
- R11: err_illegal and err_overrun stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_hi | input | 1 | 1 = upper half of the command word, 0 = lower half |
| wr_data | input | 32 | Write data |
| msg_valid | output | 1 | Outbound message offered |
| msg_ready | input | 1 | Outbound message accepted |
| msg_vector | output | 8 | Interrupt vector |
| msg_dlv | output | 3 | Delivery kind |
| msg_dmode | output | 1 | Destination mode (0 = physical) |
| msg_dest | output | 8 | Target ID, or FF for broadcast |
| msg_excl_self | output | 1 | Broadcast excludes the issuer |
| self_strobe | output | 1 | One-cycle local delivery pulse |
| self_vector | output | 8 | Vector for local delivery |
| busy | output | 1 | Command in flight |
| err_illegal | output | 1 | Sticky illegal-command flag |
| err_overrun | output | 1 | Sticky write-while-busy flag |

## Verification
The assertions assume the receiver never withdraws msg_ready in a way that matters to the issuer. They also assume that wr_data is meaningful only in cycles where wr_en is high. The stimulus drives inputs only at falling edges and toggles msg_ready at a fixed offset after the rising edge. Writes are made only at quiet points, with the one deliberate exception of the overrun scenario. The sweep covers every shorthand, both trigger settings, every defined delivery kind and both destination modes. Each command runs once with the receiver always ready and once with a stalling receiver.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DLV_W  = 3;

  typedef enum logic [1:0] {SH_NONE, SH_SELF, SH_ALL, SH_OTHERS} sh_e;
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_SELF, S_SEND} st_e;

  localparam logic [DLV_W-1:0] DLV_FIXED  = 3'b000;
  localparam logic [DLV_W-1:0] DLV_LOWPRI = 3'b001;

  typedef struct packed {
    sh_e              sh;
    logic             level;
    logic             dmode;
    logic [DLV_W-1:0] dlv;
    logic [VEC_W-1:0] vec;
  } cmd_t;

  typedef struct packed {
    logic [DLV_W-1:0]  dlv;
    logic              dmode;
    logic [VEC_W-1:0]  vec;
    logic [DEST_W-1:0] dest;
    logic              excl_self;
  } msg_t;

  function automatic logic cmd_legal(cmd_t c);
    if (c.level) return 1'b0;
    case (c.sh)
      SH_SELF, SH_ALL: return c.dlv == DLV_FIXED;
      default:         return 1'b1;
    endcase
  endfunction

  function automatic logic wants_self(cmd_t c, logic self_lp);
    case (c.sh)
      SH_SELF, SH_ALL: return 1'b1;
      SH_OTHERS:       return self_lp && (c.dlv == DLV_LOWPRI);
      default:         return 1'b0;
    endcase
  endfunction

  function automatic msg_t build_msg(cmd_t c, logic [DEST_W-1:0] stored);
    msg_t m;
    m.dlv       = c.dlv;
    m.vec       = c.vec;
    m.dmode     = (c.sh == SH_NONE) ? c.dmode : 1'b0;
    m.dest      = (c.sh == SH_NONE) ? stored : {DEST_W{1'b1}};
    m.excl_self = (c.sh == SH_OTHERS);
    return m;
  endfunction
endpackage

// File: rtl/ipi_cmd_store.sv
module ipi_cmd_store
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [31:0]       wr_data,
  input  logic              accept,
  output cmd_t              cmd_q,
  output logic [DEST_W-1:0] dest_q,
  output logic              start
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[17:16], wr_data[14:12]};

  assign start = wr_en && accept && !wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      dest_q <= '0;
    end else if (wr_en && accept) begin
      if (wr_hi) begin
        dest_q <= wr_data[31:24];
      end else begin
        cmd_q.sh    <= sh_e'(wr_data[19:18]);
        cmd_q.level <= wr_data[15];
        cmd_q.dmode <= wr_data[11];
        cmd_q.dlv   <= wr_data[10:8];
        cmd_q.vec   <= wr_data[7:0];
      end
    end
  end
endmodule

// File: rtl/ipi_seq.sv
module ipi_seq
  import ipi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wr_en,
  input  logic legal,
  input  logic need_self,
  input  logic need_msg,
  input  logic msg_ready,
  output logic busy,
  output logic msg_valid,
  output logic self_strobe,
  output logic err_illegal,
  output logic err_overrun
);
  st_e  state;
  logic check_reject;
  logic handshake_done;

  assign check_reject   = (state == S_CHECK) && !legal;
  assign handshake_done = (state == S_SEND) && msg_ready;
  assign busy           = (state != S_IDLE);
  assign msg_valid      = (state == S_SEND);
  assign self_strobe    = (state == S_SELF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      err_illegal <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (wr_en && busy) err_overrun <= 1'b1;
      case (state)
        S_IDLE:  if (start) state <= S_CHECK;
        S_CHECK: begin
          if (check_reject) begin
            state       <= S_IDLE;
            err_illegal <= 1'b1;
          end else if (need_self) begin
            state <= S_SELF;
          end else begin
            state <= S_SEND;
          end
        end
        S_SELF:  state <= need_msg ? S_SEND : S_IDLE;
        default: if (handshake_done) state <= S_IDLE;
      endcase
    end
  end

  assert_reject_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    check_reject |=> (!busy && err_illegal));
  assert_overrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> err_overrun);
  assert_illegal_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |=> err_illegal);
  assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |=> err_overrun);
  assert_self_then_msg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (self_strobe && need_msg) |=> msg_valid);
  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/ipi_issuer.sv
module ipi_issuer
  import ipi_pkg::*;
#(
  parameter bit SELF_ON_LOWPRI = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [31:0]       wr_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [VEC_W-1:0]  msg_vector,
  output logic [DLV_W-1:0]  msg_dlv,
  output logic              msg_dmode,
  output logic [DEST_W-1:0] msg_dest,
  output logic              msg_excl_self,
  output logic              self_strobe,
  output logic [VEC_W-1:0]  self_vector,
  output logic              busy,
  output logic              err_illegal,
  output logic              err_overrun
);
  cmd_t              cmd_q;
  logic [DEST_W-1:0] dest_q;
  logic              start;
  logic              legal;
  logic              need_self;
  logic              need_msg;
  msg_t              msg;

  ipi_cmd_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .accept  (!busy),
    .cmd_q   (cmd_q),
    .dest_q  (dest_q),
    .start   (start)
  );

  assign legal     = cmd_legal(cmd_q);
  assign need_self = wants_self(cmd_q, SELF_ON_LOWPRI);
  assign need_msg  = (cmd_q.sh != SH_SELF);
  assign msg       = build_msg(cmd_q, dest_q);

  ipi_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .wr_en       (wr_en),
    .legal       (legal),
    .need_self   (need_self),
    .need_msg    (need_msg),
    .msg_ready   (msg_ready),
    .busy        (busy),
    .msg_valid   (msg_valid),
    .self_strobe (self_strobe),
    .err_illegal (err_illegal),
    .err_overrun (err_overrun)
  );

  assign msg_vector    = msg.vec;
  assign msg_dlv       = msg.dlv;
  assign msg_dmode     = msg.dmode;
  assign msg_dest      = msg.dest;
  assign msg_excl_self = msg.excl_self;
  assign self_vector   = cmd_q.vec;

  assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)
      && $stable(msg_dlv) && $stable(msg_dmode) && $stable(msg_excl_self)));
  assert_bcast_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_excl_self) |-> (msg_dest == {DEST_W{1'b1}} && !msg_dmode));
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(self_strobe && msg_valid));
  assert_valid_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid || self_strobe) |-> busy);
endmodule

// File: tb/ipi_issuer_test.sv
module ipi_issuer_test;
  localparam bit SELF_LP = 1'b1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_hi = 0;
  logic [31:0] wr_data = '0;
  logic msg_ready = 0;
  logic msg_valid, msg_dmode, msg_excl_self, self_strobe, busy, err_illegal, err_overrun;
  logic [7:0] msg_vector, msg_dest, self_vector;
  logic [2:0] msg_dlv;

  int tests = 0, fails = 0;
  int ready_mode = 1;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0: msg_ready = 1'b0;
      1: msg_ready = 1'b1;
      default: msg_ready = ~msg_ready;
    endcase
  end

  ipi_issuer #(.SELF_ON_LOWPRI(SELF_LP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dlv(msg_dlv), .msg_dmode(msg_dmode), .msg_dest(msg_dest),
    .msg_excl_self(msg_excl_self), .self_strobe(self_strobe), .self_vector(self_vector),
    .busy(busy), .err_illegal(err_illegal), .err_overrun(err_overrun));

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write(bit hi, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  int n_self, n_msg, self_first, busy_cycles;
  logic [7:0] got_vec, got_dest, got_svec;
  logic [2:0] got_dlv;
  logic got_dmode, got_excl;

  task automatic observe();
    n_self = 0; n_msg = 0; self_first = 0; busy_cycles = 0;
    for (int i = 0; i < 40; i++) begin
      if (!busy) break;
      busy_cycles++;
      if (self_strobe) begin
        n_self++; got_svec = self_vector;
        if (n_msg == 0) self_first = 1;
      end
      if (msg_valid && msg_ready) begin
        n_msg++; got_vec = msg_vector; got_dest = msg_dest; got_dlv = msg_dlv;
        got_dmode = msg_dmode; got_excl = msg_excl_self;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int dl[6] = '{0, 1, 2, 4, 5, 6};
    bit any_illegal = 0;
    repeat (3) @(negedge clk);
    check(!busy && !msg_valid && !self_strobe && !err_illegal && !err_overrun,
          "R1", "reset outputs", {busy, msg_valid, self_strobe, err_illegal, err_overrun}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: upper-half write alone starts nothing
    write(1, 32'hA7000000);
    repeat (3) begin
      check(!busy && !msg_valid && !self_strobe, "R2", "hi write idle",
            {busy, msg_valid, self_strobe}, 0);
      @(negedge clk);
    end

    for (int rm = 1; rm <= 2; rm++) begin
      ready_mode = rm;
      for (int sh = 0; sh < 4; sh++)
        for (int tr = 0; tr < 2; tr++)
          for (int k = 0; k < 6; k++)
            for (int dm = 0; dm < 2; dm++) begin
              logic [7:0] vec, dst;
              logic [31:0] lo;
              bit legal, eself, emsg;
              vec = 8'(sh * 61 + tr * 29 + k * 7 + dm * 3 + rm);
              dst = 8'(vec * 5 + 17);
              write(1, {dst, 24'h0});
              lo = {12'h0, 2'(sh), 2'b00, 1'(tr), 3'b000, 1'(dm), 3'(dl[k]), vec};
              legal = (tr == 0) && ((sh == 1 || sh == 2) ? (dl[k] == 0) : 1'b1);
              eself = legal && (sh == 1 || sh == 2 || (sh == 3 && dl[k] == 1 && SELF_LP));
              emsg  = legal && (sh != 1);
              if (!legal) any_illegal = 1;
              write(0, lo);
              check(busy == 1, "R9", "busy after start", busy, 1);
              observe();
              if (!legal) begin
                check(busy_cycles == 1, "R4", "reject busy length", busy_cycles, 1);
                check(n_self == 0 && n_msg == 0, "R4", "reject outputs", n_self + n_msg, 0);
              end
              check(err_illegal == any_illegal, "R11", "illegal flag", err_illegal, any_illegal);
              if (sh == 1) check(n_self == int'(eself), "R5", "self strobes", n_self, eself);
              else if (sh == 3 && dl[k] == 1) check(n_self == int'(eself), "R8", "lowpri self", n_self, eself);
              else check(n_self == int'(eself), "R6", "self strobes", n_self, eself);
              check(n_msg == int'(emsg), "R3", "messages", n_msg, emsg);
              if (eself) check(got_svec == vec, "R5", "self vector", got_svec, vec);
              if (eself && emsg) check(self_first == 1, "R6", "self before msg", self_first, 1);
              if (emsg) begin
                check(got_vec == vec && got_dlv == 3'(dl[k]), "R3", "vector/dlv",
                      {got_vec, 1'b0, got_dlv}, {vec, 1'b0, 3'(dl[k])});
                check(got_dest == (sh == 0 ? dst : 8'hFF), "R7", "dest", got_dest, sh == 0 ? dst : 8'hFF);
                check(got_dmode == (sh == 0 ? 1'(dm) : 1'b0), "R6", "dmode", got_dmode, sh == 0 ? dm : 0);
                check(got_excl == (sh == 3), "R7", "excl_self", got_excl, sh == 3);
              end
              check(err_overrun == 0, "R10", "no overrun yet", err_overrun, 0);
            end
    end

    // R10: writes while busy are ignored
    ready_mode = 0;
    write(1, 32'h11000000);
    write(0, 32'h00000033);
    write(1, 32'h99000000);
    write(0, 32'h00000044);
    @(negedge clk);
    check(err_overrun == 1, "R10", "overrun set", err_overrun, 1);
    check(msg_valid && msg_vector == 8'h33, "R9", "held vector", msg_vector, 8'h33);
    check(msg_dest == 8'h11, "R10", "hi write ignored", msg_dest, 8'h11);
    ready_mode = 1;
    observe();
    check(n_msg == 1 && got_vec == 8'h33, "R10", "single message", n_msg, 1);
    write(0, 32'h00000055);
    observe();
    check(got_dest == 8'h11 && got_vec == 8'h55, "R10", "dest kept", got_dest, 8'h11);
    repeat (3) @(negedge clk);
    check(err_overrun && err_illegal, "R11", "flags sticky", {err_overrun, err_illegal}, 3);

    rst_n = 0;
    @(negedge clk);
    check(!err_overrun && !err_illegal && !busy, "R1", "flags cleared by reset",
          {err_overrun, err_illegal, busy}, 0);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule